// File: doc/BRIEF.md
# Deductive Fault-List Gate Evaluator

This block carries out deductive fault simulation of a small combinational netlist built from two-input gates. A fault list is a bit mask over a set of `NFLT` single stuck-at faults. Bit `f` is set when fault `f` would make that net differ from its fault-free value under the current test pattern. At the core is a combinational evaluator. It takes a gate kind, the two fault-free input values and the two input fault masks, and returns the fault-free output value and the output fault mask.

Nets are numbered in one space. The primary inputs are nets `0` to `NPI-1`, and gate `k` drives net `NPI+k`. The gate table is supplied on flat configuration ports and must be listed in level order. A pulse on `start` loads the primary-input values and their fault lists. The sequencer then evaluates one gate per clock and writes each result back into the net registers. At the end it reports the faults that the pattern detects at the selected primary outputs and ORs them into a sticky coverage mask. Any net can be read at any time through a combinational read port.

Top module: `fault_list_deducer`

## Requirements
- R1: Gate kind encoding is 0 = AND, 1 = NAND, 2 = OR, 3 = NOR. The fault-free value written to a gate's net is the corresponding Boolean function of its two source nets.
- R2: When neither input carries the controlling value (0 for AND/NAND, 1 for OR/NOR), the output list is the union of the two input lists, plus the output's own fault.
- R3: When at least one input carries the controlling value, the output list is the intersection of the lists of the controlling inputs, minus the lists of the non-controlling inputs, plus the output's own fault. For an AND-family gate this gives x,y = 00 → Lx∧Ly, 01 → Lx∖Ly, 10 → Ly∖Lx. For an OR-family gate it gives 11 → Lx∧Ly, 01 → Ly∖Lx, 10 → Lx∖Ly.
- R4: The own fault is the output's stuck-at fault opposite to its fault-free value: index `g_sa0` when the value is 1, `g_sa1` when it is 0. It is added only if its bit in `flt_valid` is set; otherwise nothing is added.
- R5: On an accepted start, each primary input net takes its value from `pi_val`. Its list holds only the stuck-at fault opposite to that value (`pi_sa0` slot when the value is 1, `pi_sa1` slot when it is 0), and only if that fault is valid; otherwise the list is empty.
- R6: Gates are evaluated in table order, one per clock. `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse that appears `NGATE+1` clock edges after the start edge.
- R7: When `done` is high, `det_mask` is the OR of the lists of all nets flagged in `po_mask`, and `cov_mask` is its previous value ORed with `det_mask`. `cov_clr` empties `cov_mask`.
- R8: `start` is ignored while `busy` is high. Such a start neither restarts the run nor changes its results.
- R9: `rd_val` and `rd_list` show the stored value and list of net `rd_sel` in the same cycle.
- R10: After reset `busy`, `done`, `det_mask` and `cov_mask` are zero, and every net reads value 0 with an empty list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one pattern when idle |
| cov_clr | input | 1 | Empty the coverage mask |
| pi_val | input | NPI | Fault-free test pattern, bit n drives net n |
| pi_sa0 | input | NPI*FW | Stuck-at-0 fault index of each primary input |
| pi_sa1 | input | NPI*FW | Stuck-at-1 fault index of each primary input |
| flt_valid | input | NFLT | Modeled fault set |
| g_kind | input | 2*NGATE | Kind of each gate |
| g_src_a | input | NW*NGATE | First source net of each gate |
| g_src_b | input | NW*NGATE | Second source net of each gate |
| g_sa0 | input | FW*NGATE | Stuck-at-0 fault index of each gate output |
| g_sa1 | input | FW*NGATE | Stuck-at-1 fault index of each gate output |
| po_mask | input | NNET | Nets that are primary outputs |
| rd_sel | input | NW | Net selected for reading |
| rd_val | output | 1 | Fault-free value of the selected net |
| rd_list | output | NFLT | Fault list of the selected net |
| busy | output | 1 | Pattern evaluation in progress |
| done | output | 1 | One-cycle end-of-pattern pulse |
| det_mask | output | NFLT | Faults detected by the last pattern |
| cov_mask | output | NFLT | Sticky OR of all detected faults |

## Verification
The assertions assume that the gate table is levelized, so each gate reads only primary inputs or earlier gates. They also assume that every source index names an existing net, and that `flt_valid` and the gate table are held steady while `busy` is high. The bench keeps to these conditions: it changes configuration only between runs, and it changes `pi_val` during a run only in the ignored-start test, where that is the intended stimulus. A one-gate instance is swept over every gate kind, every input value pair, every overlap of fault indices and two fault sets, against a table model. A twelve-net instance runs two patterns whose lists are worked out by hand.

// File: rtl/fault_list_deducer.sv
module fault_list_deducer #(
  parameter int NPI   = 5,
  parameter int NGATE = 7,
  parameter int NFLT  = 16,
  localparam int NNET = NPI + NGATE,
  localparam int NW   = $clog2(NNET),
  localparam int FW   = $clog2(NFLT),
  localparam int GW   = $clog2(NGATE + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  cov_clr,
  input  logic [NPI-1:0]        pi_val,
  input  logic [NPI*FW-1:0]     pi_sa0,
  input  logic [NPI*FW-1:0]     pi_sa1,
  input  logic [NFLT-1:0]       flt_valid,
  input  logic [2*NGATE-1:0]    g_kind,
  input  logic [NW*NGATE-1:0]   g_src_a,
  input  logic [NW*NGATE-1:0]   g_src_b,
  input  logic [FW*NGATE-1:0]   g_sa0,
  input  logic [FW*NGATE-1:0]   g_sa1,
  input  logic [NNET-1:0]       po_mask,
  input  logic [NW-1:0]         rd_sel,
  output logic                  rd_val,
  output logic [NFLT-1:0]       rd_list,
  output logic                  busy,
  output logic                  done,
  output logic [NFLT-1:0]       det_mask,
  output logic [NFLT-1:0]       cov_mask
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t              st;
  logic [GW-1:0]    gidx;
  logic [NNET-1:0]  nval;
  logic [NFLT-1:0]  nlst [NNET];

  logic [1:0]       kind;
  logic [NW-1:0]    sa, sb;
  logic [FW-1:0]    o0, o1;

  always_comb begin
    kind = '0; sa = '0; sb = '0; o0 = '0; o1 = '0;
    for (int k = 0; k < NGATE; k++)
      if (GW'(k) == gidx) begin
        kind = g_kind[2*k +: 2];
        sa   = g_src_a[NW*k +: NW];
        sb   = g_src_b[NW*k +: NW];
        o0   = g_sa0[FW*k +: FW];
        o1   = g_sa1[FW*k +: FW];
      end
  end

  logic            xv, yv, ctl, inv, xc, yc, ez;
  logic [NFLT-1:0] lx, ly, base, own_bit, elz;
  logic [FW-1:0]   own;

  assign xv  = nval[sa];
  assign yv  = nval[sb];
  assign lx  = nlst[sa];
  assign ly  = nlst[sb];
  assign ctl = kind[1];
  assign inv = kind[0];
  assign xc  = (xv == ctl);
  assign yc  = (yv == ctl);
  assign ez  = (xc | yc) ? (ctl ^ inv) : ~(ctl ^ inv);

  always_comb
    case ({xc, yc})
      2'b00:   base = lx | ly;
      2'b11:   base = lx & ly;
      2'b10:   base = lx & ~ly;
      default: base = ly & ~lx;
    endcase

  assign own     = ez ? o0 : o1;
  assign own_bit = flt_valid[own] ? (NFLT'(1) << own) : '0;
  assign elz     = base | own_bit;

  logic [NFLT-1:0] det_now;
  always_comb begin
    det_now = '0;
    for (int n = 0; n < NNET; n++)
      if (po_mask[n]) det_now = det_now | nlst[n];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      gidx     <= '0;
      done     <= 1'b0;
      det_mask <= '0;
      cov_mask <= '0;
      nval     <= '0;
      for (int n = 0; n < NNET; n++) nlst[n] <= '0;
    end else begin
      done <= (st == S_FIN);
      cov_mask <= (cov_clr ? '0 : cov_mask) | ((st == S_FIN) ? det_now : '0);
      case (st)
        S_IDLE:
          if (start) begin
            for (int n = 0; n < NPI; n++) begin
              logic [FW-1:0] opp;
              opp = pi_val[n] ? pi_sa0[FW*n +: FW] : pi_sa1[FW*n +: FW];
              nval[n] <= pi_val[n];
              nlst[n] <= flt_valid[opp] ? (NFLT'(1) << opp) : '0;
            end
            gidx <= '0;
            st   <= S_RUN;
          end
        S_RUN: begin
          for (int n = NPI; n < NNET; n++)
            if (GW'(n - NPI) == gidx) begin
              nval[n] <= ez;
              nlst[n] <= elz;
            end
          if (gidx == GW'(NGATE - 1)) st <= S_FIN;
          else gidx <= gidx + 1'b1;
        end
        default: begin
          det_mask <= det_now;
          st       <= S_IDLE;
        end
      endcase
    end

  assign busy    = (st != S_IDLE);
  assign rd_val  = nval[rd_sel];
  assign rd_list = nlst[rd_sel];

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_gate_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && gidx != GW'(NGATE - 1)) |=> (st == S_RUN && gidx == $past(gidx) + 1'b1));
  assert_cov_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cov_clr |=> ((cov_mask & $past(cov_mask)) == $past(cov_mask)));
  assert_list_modeled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> ((elz & ~flt_valid) == '0));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && gidx != GW'(NGATE - 1)) |=> (st == S_RUN));

endmodule

// File: tb/fault_list_deducer_bench.sv
module fault_list_deducer_bench;
  logic clk = 0;
  always #2 clk = ~clk;
  logic rst_n = 0;

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Twelve-net circuit: a b c d e | f g h i j k m
  logic        start = 0, cov_clr = 0;
  logic [4:0]  pi_val = 0;
  logic [19:0] pi_sa0, pi_sa1;
  logic [15:0] flt_valid = 16'h03FF;
  logic [13:0] g_kind;
  logic [27:0] g_src_a, g_src_b, g_sa0, g_sa1;
  logic [11:0] po_mask = 12'h800;
  logic [3:0]  rd_sel = 0;
  logic        rd_val, busy, done;
  logic [15:0] rd_list, det_mask, cov_mask;

  initial begin
    pi_sa0 = {4'd6, 4'd11, 4'd3, 4'd10, 4'd0};
    pi_sa1 = {4'd12, 4'd5, 4'd4, 4'd2, 4'd1};
    g_kind  = {2'd2, 2'd2, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0};
    g_src_a = {4'd10, 4'd8, 4'd5, 4'd3, 4'd2, 4'd2, 4'd0};
    g_src_b = {4'd9, 4'd4, 4'd6, 4'd7, 4'd2, 4'd2, 4'd1};
    g_sa0   = {4'd15, 4'd15, 4'd15, 4'd15, 4'd8, 4'd7, 4'd13};
    g_sa1   = {4'd15, 4'd15, 4'd15, 4'd15, 4'd9, 4'd14, 4'd13};
  end

  fault_list_deducer u_fault_list_deducer (
    .clk, .rst_n, .start, .cov_clr, .pi_val, .pi_sa0, .pi_sa1, .flt_valid,
    .g_kind, .g_src_a, .g_src_b, .g_sa0, .g_sa1, .po_mask, .rd_sel,
    .rd_val, .rd_list, .busy, .done, .det_mask, .cov_mask);

  // One-gate instance for the sweep
  logic       s_start = 0, s_cov_clr = 0;
  logic [1:0] s_pi_val = 0;
  logic [3:0] s_pi_sa = 0;
  logic [3:0] s_valid = 4'hF;
  logic [1:0] s_kind = 0, s_o0 = 0, s_o1 = 0, s_rd = 2'd2;
  logic       s_rd_val, s_busy, s_done;
  logic [3:0] s_rd_list, s_det, s_cov;

  fault_list_deducer #(.NPI(2), .NGATE(1), .NFLT(4)) u_fault_list_deducer_g1 (
    .clk, .rst_n, .start(s_start), .cov_clr(s_cov_clr), .pi_val(s_pi_val),
    .pi_sa0(s_pi_sa), .pi_sa1(s_pi_sa), .flt_valid(s_valid), .g_kind(s_kind),
    .g_src_a(2'd0), .g_src_b(2'd1), .g_sa0(s_o0), .g_sa1(s_o1), .po_mask(3'b100),
    .rd_sel(s_rd), .rd_val(s_rd_val), .rd_list(s_rd_list), .busy(s_busy),
    .done(s_done), .det_mask(s_det), .cov_mask(s_cov));

  function automatic logic [3:0] model(input logic [1:0] kind, input logic xv, yv,
      input logic [3:0] lx, ly, input logic [1:0] o0, o1, input logic [3:0] vm,
      output logic z);
    logic [3:0] s; logic [1:0] own;
    if (!kind[1]) begin
      z = xv & yv;
      case ({xv, yv}) 2'b00: s = lx & ly; 2'b01: s = lx & ~ly;
                      2'b10: s = ly & ~lx; default: s = lx | ly; endcase
    end else begin
      z = xv | yv;
      case ({xv, yv}) 2'b00: s = lx | ly; 2'b01: s = ly & ~lx;
                      2'b10: s = lx & ~ly; default: s = lx & ly; endcase
    end
    z = z ^ kind[0];
    own = z ? o0 : o1;
    return s | (vm[own] ? 4'(1) << own : 4'd0);
  endfunction

  task automatic run_big(output int cyc);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    cyc = 1;
    chk("R6 busy during run", 32'(busy), 1);
    while (!done && cyc < 50) begin @(negedge clk); cyc++; end
  endtask

  task automatic run_small();
    int c = 0;
    @(negedge clk) s_start = 1;
    @(negedge clk) s_start = 0;
    while (!s_done && c < 20) begin @(negedge clk); c++; end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 cov", 32'(cov_mask), 0);
    chk("R10 det", 32'(det_mask), 0);
    rd_sel = 4'd11; #1;
    chk("R10 net list", 32'(rd_list), 0);
    chk("R10 net val", 32'(rd_val), 0);
    rst_n = 1;

    // Pattern 1: a..e = 0 0 1 1 0
    pi_val = 5'b01100;
    run_big(cyc);
    chk("R6 latency", 32'(cyc), 9);
    chk("R7 det p1", 32'(det_mask), 32'h0100);
    chk("R7 cov p1", 32'(cov_mask), 32'h0100);
    rd_sel = 4'd0; #1;  chk("R5 list a p1", 32'(rd_list), 32'h0002);
    rd_sel = 4'd3; #1;  chk("R5 invalid d p1", 32'(rd_list), 0);
    rd_sel = 4'd5; #1;  chk("R3 list f p1", 32'(rd_list), 0);
    rd_sel = 4'd9; #1;  chk("R3 list j p1", 32'(rd_list), 32'h0088);
                        chk("R1 val j p1", 32'(rd_val), 0);
    rd_sel = 4'd8; #1;  chk("R2 list i p1", 32'(rd_list), 32'h0108);
    rd_sel = 4'd11; #1; chk("R9 val m p1", 32'(rd_val), 1);
                        chk("R3 list m p1", 32'(rd_list), 32'h0100);
    @(negedge clk);
    chk("R6 done pulse", 32'(done), 0);

    // Pattern 2: a..e = 1 1 0 1 0
    pi_val = 5'b01011;
    run_big(cyc);
    chk("R7 det p2", 32'(det_mask), 32'h0211);
    chk("R7 cov p2", 32'(cov_mask), 32'h0311);
    rd_sel = 4'd8; #1;  chk("R3 list i p2", 32'(rd_list), 32'h0210);
    rd_sel = 4'd11; #1; chk("R2 list m p2", 32'(rd_list), 32'h0211);
                        chk("R1 val m p2", 32'(rd_val), 0);

    // Ignored start while busy
    pi_val = 5'b01100;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    @(negedge clk) pi_val = 5'b01011; start = 1;
    @(negedge clk) start = 0;
    cyc = 3;
    while (!done && cyc < 50) begin @(negedge clk); cyc++; end
    chk("R8 latency kept", 32'(cyc), 9);
    chk("R8 det of first pattern", 32'(det_mask), 32'h0100);
    repeat (3) begin
      @(negedge clk);
      chk("R8 no second run", 32'({busy, done}), 0);
    end

    @(negedge clk) cov_clr = 1;
    @(negedge clk) cov_clr = 0;
    chk("R7 cov cleared", 32'(cov_mask), 0);

    // One-gate sweep
    for (int vsel = 0; vsel < 2; vsel++)
      for (int kd = 0; kd < 4; kd++)
        for (int xy = 0; xy < 4; xy++)
          for (int ix = 0; ix < 4; ix++)
            for (int iy = 0; iy < 4; iy++)
              for (int ow = 0; ow < 4; ow++) begin
                logic [3:0] vm, lx, ly, el; logic z, xv, yv;
                string rq;
                vm = vsel ? 4'b0101 : 4'hF;
                xv = xy[1]; yv = xy[0];
                s_valid = vm; s_kind = 2'(kd); s_pi_val = {yv, xv};
                s_pi_sa = {2'(iy), 2'(ix)};
                s_o0 = 2'(ow); s_o1 = 2'(ow + 1);
                run_small();
                lx = vm[ix] ? 4'(1) << ix : 4'd0;
                ly = vm[iy] ? 4'(1) << iy : 4'd0;
                el = model(2'(kd), xv, yv, lx, ly, 2'(ow), 2'(ow + 1), vm, z);
                rq = ((xv == kd[1]) || (yv == kd[1])) ? "R3/R4 gate list" : "R2/R4 gate list";
                s_rd = 2'd2; #1;
                chk(rq, 32'(s_rd_list), 32'(el));
                chk("R1 gate value", 32'(s_rd_val), 32'(z));
                chk("R7 det single", 32'(s_det), 32'(el));
                s_rd = 2'd0; #1;
                chk("R5 input list", 32'(s_rd_list), 32'(lx));
              end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule